// File: doc/BRIEF.md
# Multi-Operand Computation Unit Sequencer

This block sequences the register-file traffic of one function unit in a scoreboard-style out-of-order core. The unit can read up to three source operands and write up to two results. Each operand and each result has its own request line and its own grant line to the register file. An operand or result is served as soon as its own grant arrives. It does not wait for a single combined grant.

An issue pulse on an idle unit makes it busy. It then raises a read request for every operand flagged as needed. Read grants may come one at a time, in any order, several in one cycle, or all together. Each grant latches that operand's data and withdraws that request. Once every needed operand has been read, the unit waits for an execution-done pulse, which also latches the results. Only then does it raise its write requests. Write grants are taken independently. The unit goes idle after the last needed result has been granted.

All requests come from registered state, so the loop from request through the arbiter and back to the grant never closes combinationally.

Top module: `mcu_seq`

## Requirements
- R1: After reset the unit is idle: busy_o, rd_req_o and wr_req_o are all zero, and opnd_o and res_o are zero.
- R2: An issue_i pulse while idle makes busy_o high after the next clock edge. From that edge on, rd_req_o equals the rd_need_i value sampled at that edge.
- R3: A go_rd_i[i] sampled while rd_req_o[i] is high clears rd_req_o[i] after that edge. The same edge loads operand slice i of opnd_o (bits i*DW upward) from opnd_i. Grants are taken per operand, in any order or combination.
- R4: A go_rd_i[i] while rd_req_o[i] is low has no effect: opnd_o slice i and the requests stay unchanged.
- R5: wr_req_o stays zero until every needed operand has been read and an exec_done_i pulse has then been accepted. An exec_done_i seen while a read is still outstanding is ignored.
- R6: An accepted exec_done_i loads res_o from exec_res_i. From the following edge, wr_req_o equals the wr_need_i value sampled at issue.
- R7: A go_wr_i[j] sampled while wr_req_o[j] is high clears that request after the edge. Once the last needed result is granted, busy_o drops after that same edge.
- R8: issue_i while busy is ignored: the operation in flight keeps its requests and needs.
- R9: An operand whose need flag is clear counts as already read, and a result whose need flag is clear counts as already written. An operation needing no result goes idle at the edge that accepts exec_done_i.
- R10: A request line is never high while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue pulse for a new operation |
| rd_need_i | input | N_RD | Operands used by the issued operation |
| wr_need_i | input | N_WR | Results produced by the issued operation |
| go_rd_i | input | N_RD | Per-operand read grants |
| go_wr_i | input | N_WR | Per-result write grants |
| opnd_i | input | N_RD*DW | Register-file read data, one slice per operand |
| exec_done_i | input | 1 | Execution finished pulse |
| exec_res_i | input | N_WR*DW | Results from the execution datapath |
| busy_o | output | 1 | Operation in flight |
| rd_req_o | output | N_RD | Per-operand read requests |
| wr_req_o | output | N_WR | Per-result write requests |
| opnd_o | output | N_RD*DW | Latched operands |
| res_o | output | N_WR*DW | Latched results |

## Verification
Every state change in this unit lands exactly one edge after its cause. Busy and the read requests follow an accepted issue on the next edge. A read grant drops its request and shows the operand on the next edge. An accepted done raises the write requests and shows the results on the next edge. The final write grant clears busy on the next edge. The bench changes inputs on the falling edge and advances a cycle-level model of these rules by one step per cycle. It compares every output against the model on the following falling edge, so each result is checked exactly one edge after the stimulus that caused it.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_GATHER = 2'd1,
      PH_WRITE  = 2'd2
   } mcu_phase_e;

endpackage

// File: rtl/mcu_slot.sv
module mcu_slot #(
   parameter int DW      = 16,
   parameter bit CAPTURE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          need_i,
   input  logic          enable_i,
   input  logic          go_i,
   input  logic [DW-1:0] din_i,
   output logic          req_o,
   output logic          done_o,
   output logic [DW-1:0] q_o
);

   logic done_q;
   logic take;

   assign req_o  = enable_i & ~done_q;
   assign take   = req_o & go_i;
   assign done_o = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      done_q <= 1'b0;
      else if (load_i) done_q <= ~need_i;
      else if (take)   done_q <= 1'b1;
   end

   generate
      if (CAPTURE) begin : g_capture
         logic [DW-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (take) data_q <= din_i;
         end
         assign q_o = data_q;
      end else begin : g_flag_only
         logic unused_din;
         assign unused_din = ^din_i;
         assign q_o = '0;
      end
   endgenerate

   // R3 / R7: a served request is withdrawn on the next edge
   a_r3_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && go_i && !load_i) |=> !req_o);
   // R10: no request without the enable from the controller
   a_r10_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> enable_i);

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
   import mcu_pkg::*;
#(
   parameter int RW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_i,
   input  logic          all_rd_i,
   input  logic          all_wr_i,
   input  logic          all_wr_nx_i,
   input  logic          exec_done_i,
   input  logic [RW-1:0] res_i,
   output logic          busy_o,
   output logic          rd_en_o,
   output logic          wr_en_o,
   output logic          load_o,
   output logic [RW-1:0] res_o
);

   mcu_phase_e phase_q, phase_d;
   logic       exec_acc;
   logic [RW-1:0] res_q;

   assign load_o   = (phase_q == PH_IDLE) & issue_i;
   assign exec_acc = (phase_q == PH_GATHER) & all_rd_i & exec_done_i;
   assign busy_o   = (phase_q != PH_IDLE);
   assign rd_en_o  = (phase_q == PH_GATHER);
   assign wr_en_o  = (phase_q == PH_WRITE);
   assign res_o    = res_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (issue_i) phase_d = PH_GATHER;
         PH_GATHER: if (exec_acc) phase_d = all_wr_i ? PH_IDLE : PH_WRITE;
         PH_WRITE:  if (all_wr_nx_i) phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         res_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (exec_acc) res_q <= res_i;
      end
   end

   // R5: writing is only entered from a completed gather
   a_r5_write_after_gather: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !$past(wr_en_o)) |-> $past(all_rd_i && exec_done_i));
   // R2: an idle issue makes the unit busy
   a_r2_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && issue_i) |=> busy_o);

endmodule

// File: rtl/mcu_seq.sv
module mcu_seq #(
   parameter int N_RD = 3,
   parameter int N_WR = 2,
   parameter int DW   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_i,
   input  logic [N_RD-1:0]      rd_need_i,
   input  logic [N_WR-1:0]      wr_need_i,
   input  logic [N_RD-1:0]      go_rd_i,
   input  logic [N_WR-1:0]      go_wr_i,
   input  logic [N_RD*DW-1:0]   opnd_i,
   input  logic                 exec_done_i,
   input  logic [N_WR*DW-1:0]   exec_res_i,
   output logic                 busy_o,
   output logic [N_RD-1:0]      rd_req_o,
   output logic [N_WR-1:0]      wr_req_o,
   output logic [N_RD*DW-1:0]   opnd_o,
   output logic [N_WR*DW-1:0]   res_o
);

   localparam int RW = N_WR * DW;

   generate
      if (N_RD < 1 || N_RD > 8) begin : g_bad_nrd
         $error("mcu_seq: N_RD out of range");
      end
      if (N_WR < 1 || N_WR > 8) begin : g_bad_nwr
         $error("mcu_seq: N_WR out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("mcu_seq: DW must be positive");
      end
   endgenerate

   logic            load, rd_en, wr_en;
   logic [N_RD-1:0] rd_done;
   logic [N_WR-1:0] wr_done;
   logic            all_wr_nx;

   assign all_wr_nx = &(wr_done | (wr_req_o & go_wr_i));

   mcu_ctrl #(.RW(RW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_i     (issue_i),
      .all_rd_i    (&rd_done),
      .all_wr_i    (&wr_done),
      .all_wr_nx_i (all_wr_nx),
      .exec_done_i (exec_done_i),
      .res_i       (exec_res_i),
      .busy_o      (busy_o),
      .rd_en_o     (rd_en),
      .wr_en_o     (wr_en),
      .load_o      (load),
      .res_o       (res_o)
   );

   for (genvar i = 0; i < N_RD; i++) begin : g_rd
      mcu_slot #(.DW(DW), .CAPTURE(1'b1)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_i   (load),
         .need_i   (rd_need_i[i]),
         .enable_i (rd_en),
         .go_i     (go_rd_i[i]),
         .din_i    (opnd_i[i*DW +: DW]),
         .req_o    (rd_req_o[i]),
         .done_o   (rd_done[i]),
         .q_o      (opnd_o[i*DW +: DW])
      );
   end

   for (genvar j = 0; j < N_WR; j++) begin : g_wr
      logic [0:0] unused_q;
      mcu_slot #(.DW(1), .CAPTURE(1'b0)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_i   (load),
         .need_i   (wr_need_i[j]),
         .enable_i (wr_en),
         .go_i     (go_wr_i[j]),
         .din_i    (1'b0),
         .req_o    (wr_req_o[j]),
         .done_o   (wr_done[j]),
         .q_o      (unused_q)
      );
   end

   // R5: no write request while any read is outstanding
   a_r5_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_req_o) |-> (rd_req_o == '0));
   // R7: last write grant returns the unit to idle
   a_r7_idle_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
      ((|wr_req_o) && all_wr_nx) |=> !busy_o);
   // R8: issue while busy adds no new read request
   a_r8_issue_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && issue_i) |=> ((rd_req_o & ~$past(rd_req_o)) == '0));
   // R10: idle unit presents no request
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (rd_req_o == '0 && wr_req_o == '0));

endmodule

// File: tb/test_mcu_seq.sv
module test_mcu_seq;

   localparam int N_RD = 3;
   localparam int N_WR = 2;
   localparam int DW   = 16;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                issue_i = 1'b0;
   logic [N_RD-1:0]     rd_need_i = '0;
   logic [N_WR-1:0]     wr_need_i = '0;
   logic [N_RD-1:0]     go_rd_i = '0;
   logic [N_WR-1:0]     go_wr_i = '0;
   logic [N_RD*DW-1:0]  opnd_i = '0;
   logic                exec_done_i = 1'b0;
   logic [N_WR*DW-1:0]  exec_res_i = '0;
   logic                busy_o;
   logic [N_RD-1:0]     rd_req_o;
   logic [N_WR-1:0]     wr_req_o;
   logic [N_RD*DW-1:0]  opnd_o;
   logic [N_WR*DW-1:0]  res_o;

   mcu_seq #(.N_RD(N_RD), .N_WR(N_WR), .DW(DW)) i_mcu_seq (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .rd_need_i(rd_need_i),
      .wr_need_i(wr_need_i), .go_rd_i(go_rd_i), .go_wr_i(go_wr_i),
      .opnd_i(opnd_i), .exec_done_i(exec_done_i), .exec_res_i(exec_res_i),
      .busy_o(busy_o), .rd_req_o(rd_req_o), .wr_req_o(wr_req_o),
      .opnd_o(opnd_o), .res_o(res_o)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model of the requirements
   logic                m_busy = 1'b0, m_exec = 1'b0;
   logic [N_RD-1:0]     m_rd_done = '0;
   logic [N_WR-1:0]     m_wr_done = '0;
   logic [N_RD*DW-1:0]  m_opnd = '0;
   logic [N_WR*DW-1:0]  m_res = '0;

   function automatic logic [N_RD-1:0] exp_rd_req();
      return (m_busy && !m_exec) ? ~m_rd_done : '0;
   endfunction

   function automatic logic [N_WR-1:0] exp_wr_req();
      return (m_busy && m_exec) ? ~m_wr_done : '0;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      logic [N_RD-1:0] rq;
      logic [N_WR-1:0] wq;
      rq = exp_rd_req();
      wq = exp_wr_req();
      if (!m_busy) begin
         if (issue_i) begin
            m_busy = 1'b1; m_exec = 1'b0;
            m_rd_done = ~rd_need_i; m_wr_done = ~wr_need_i;
         end
      end else if (!m_exec) begin
         if ((&m_rd_done) && exec_done_i) begin
            m_exec = 1'b1; m_res = exec_res_i;
            if (&m_wr_done) m_busy = 1'b0;
         end
         for (int i = 0; i < N_RD; i++)
            if (rq[i] && go_rd_i[i]) begin
               m_rd_done[i] = 1'b1;
               m_opnd[i*DW +: DW] = opnd_i[i*DW +: DW];
            end
      end else begin
         for (int j = 0; j < N_WR; j++)
            if (wq[j] && go_wr_i[j]) m_wr_done[j] = 1'b1;
         if (&m_wr_done) m_busy = 1'b0;
      end
   endtask

   task automatic compare_all();
      chk("R2 R7 R9 busy", 64'(busy_o), 64'(m_busy));
      chk("R3 R10 rd_req", 64'(rd_req_o), 64'(exp_rd_req()));
      chk("R5 R6 wr_req", 64'(wr_req_o), 64'(exp_wr_req()));
      chk("R3 R4 opnd", 64'(opnd_o), 64'(m_opnd));
      chk("R6 res", 64'(res_o), 64'(m_res));
   endtask

   // inputs are set just after a falling edge; outputs compared on the next one
   task automatic step(input logic iss, input logic [N_RD-1:0] rn, input logic [N_WR-1:0] wn,
                       input logic [N_RD-1:0] gr, input logic [N_WR-1:0] gw, input logic ed);
      issue_i = iss; rd_need_i = rn; wr_need_i = wn;
      go_rd_i = gr; go_wr_i = gw; exec_done_i = ed;
      opnd_i = {$urandom, $urandom};
      exec_res_i = $urandom;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [N_RD*DW-1:0] keep;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 rd_req", 64'(rd_req_o), 64'd0);
      chk("R1 wr_req", 64'(wr_req_o), 64'd0);
      chk("R1 opnd", 64'(opnd_o), 64'd0);
      chk("R1 res", 64'(res_o), 64'd0);
      rst_n = 1'b1;

      // R2: issue with all needed
      step(1'b1, 3'b111, 2'b11, 3'b000, 2'b00, 1'b0);
      chk("R2 busy after issue", 64'(busy_o), 64'd1);
      chk("R2 rd_req equals needs", 64'(rd_req_o), 64'b111);
      // R8: issue while busy ignored
      step(1'b1, 3'b000, 2'b00, 3'b000, 2'b00, 1'b0);
      chk("R8 rd_req kept", 64'(rd_req_o), 64'b111);
      // R5: early exec_done ignored; R3 out-of-order single grants
      step(1'b0, 3'b000, 2'b00, 3'b100, 2'b00, 1'b1);
      chk("R5 early done ignored", 64'(wr_req_o), 64'd0);
      chk("R3 grant 2 clears req", 64'(rd_req_o), 64'b011);
      keep = opnd_o;
      // R4: repeated grant on a served operand is ignored
      step(1'b0, 3'b000, 2'b00, 3'b100, 2'b00, 1'b0);
      chk("R4 served slot unchanged", 64'(opnd_o[2*DW +: DW]), 64'(keep[2*DW +: DW]));
      step(1'b0, 3'b000, 2'b00, 3'b011, 2'b00, 1'b0);
      step(1'b0, 3'b000, 2'b00, 3'b000, 2'b00, 1'b1);
      chk("R6 wr_req after done", 64'(wr_req_o), 64'b11);
      step(1'b0, 3'b000, 2'b00, 3'b000, 2'b10, 1'b0);
      chk("R7 still busy", 64'(busy_o), 64'd1);
      step(1'b0, 3'b000, 2'b00, 3'b000, 2'b01, 1'b0);
      chk("R7 idle after last write", 64'(busy_o), 64'd0);

      // R9: no operands, no results
      step(1'b1, 3'b000, 2'b00, 3'b000, 2'b00, 1'b0);
      chk("R9 no read request", 64'(rd_req_o), 64'd0);
      step(1'b0, 3'b000, 2'b00, 3'b000, 2'b00, 1'b1);
      chk("R9 idle at done", 64'(busy_o), 64'd0);

      // R4: grant for an unneeded operand
      step(1'b1, 3'b010, 2'b01, 3'b000, 2'b00, 1'b0);
      keep = opnd_o;
      step(1'b0, 3'b000, 2'b00, 3'b101, 2'b00, 1'b0);
      chk("R4 unneeded slot 0 unchanged", 64'(opnd_o[DW-1:0]), 64'(keep[DW-1:0]));
      // all reads granted together in one cycle
      step(1'b0, 3'b000, 2'b00, 3'b111, 2'b11, 1'b0);
      step(1'b0, 3'b000, 2'b00, 3'b000, 2'b00, 1'b1);
      step(1'b0, 3'b000, 2'b00, 3'b000, 2'b11, 1'b0);
      chk("R7 both write grants", 64'(busy_o), 64'd0);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 4) == 0, 3'($urandom), 2'($urandom),
              3'($urandom), 2'($urandom), ($urandom % 3) == 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule